// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a one-way first-in first-out buffer between two clock domains. A producer writes words on the write clock and a consumer takes them on the read clock; the two clocks may be unrelated or identical. The read and write pointers cross between the domains as Gray code, each through a pair of flip-flops. A strap input fixes the read timing after reset. In standard timing, a read request returns the next word one clock later. In fall-through timing, the oldest word is shown on the output without any request, and a read request takes it.

Two active-low warning flags give early notice of the fill level: one when the buffer is nearly drained, one when it is nearly full. The two thresholds come from a two-bit select sampled while reset is held. The select picks one of three preset values for both flags, or, when it is zero, asks for the thresholds to be taken from the first two words written after reset.

Top module: `dcfifo_progflag`

## Requirements
- R1: A port acts on a rising edge of its own clock only when its select (`wr_cs_n`, `rd_cs_n`) is 0 and its enable (`wr_en`, `rd_en`) is 1. Otherwise it does nothing.
- R2: With `std_mode`=1, `rd_ready` is 1 while words are stored. A read request loads the oldest word into `rdata`, where it is visible after that read edge. Words come out in the order they were written.
- R3: With `std_mode`=0, the oldest stored word appears on `rdata` with `rd_ready`=1 and no read request. A read request moves `rdata` to the next word, or drops `rd_ready` to 0 when no other word is stored.
- R4: `wr_ready` is 1 while fewer than DEPTH (256) words are stored and 0 when DEPTH words are stored.
- R5: `near_empty_n` is 0 when the held word count is at or below the almost-empty threshold, and 1 when it is above. In fall-through timing the held count includes the word shown on `rdata`.
- R6: `near_full_n` is 0 when the number of free locations is at or below the almost-full threshold, and 1 when it is above.
- R7: The `thr_sel` value present at reset release sets both thresholds to a preset: 01 gives 8, 10 gives 16 and 11 gives 64.
- R8: When `thr_sel` is 00 at reset release, bits [7:0] of the first write become the almost-empty threshold and bits [7:0] of the second write become the almost-full threshold. Neither of these words is stored. Storage starts with the third write.
- R9: A write while DEPTH words are stored is dropped, and a read while nothing is stored is ignored. Neither one moves a pointer.
- R10: While `rst_n` is 0, `rd_ready`=0, `wr_ready`=0, `near_empty_n`=0 and `near_full_n`=1. After release, `wr_ready` rises to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| std_mode | input | 1 | 1 = standard timing, 0 = fall-through; static |
| thr_sel | input | 2 | Threshold select, captured while in reset |
| wr_cs_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write enable |
| wdata | input | 36 | Write data |
| rd_cs_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read enable |
| rdata | output | 36 | Read data register |
| rd_ready | output | 1 | Standard: not empty; fall-through: output word valid |
| wr_ready | output | 1 | Standard: not full; fall-through: space to write |
| near_empty_n | output | 1 | Almost-empty flag, read domain, active low |
| near_full_n | output | 1 | Almost-full flag, write domain, active low |

## Verification
The assertions assume that `std_mode` and `thr_sel` do not change once reset is released. They also assume that the threshold registers are written only during the load phase, before any data word can reach the read domain, so the read side treats the almost-empty threshold as quasi-static. The bench respects both assumptions. It changes the mode and select only while `rst_n` is 0, holds reset across several edges of both clocks, and waits out the synchroniser delay before it samples any flag from the other domain. All inputs change on the falling edge of their own clock. The two clock periods are chosen so that no input change coincides with a rising edge of either clock.

// File: rtl/dcfifo_progflag.sv
module dcfifo_progflag #(
  parameter int DW   = 36,
  parameter int AW   = 8,
  parameter int PRE1 = 8,
  parameter int PRE2 = 16,
  parameter int PRE3 = 64
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          std_mode,
  input  logic [1:0]    thr_sel,
  input  logic          wr_cs_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rd_ready,
  output logic          wr_ready,
  output logic          near_empty_n,
  output logic          near_full_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int CW    = PW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW-1:0] preset(input logic [1:0] s);
    case (s)
      2'b01:   return AW'(PRE1);
      2'b10:   return AW'(PRE2);
      2'b11:   return AW'(PRE3);
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rg_m, rg_s;
  logic [1:0]    ld_cnt;
  logic [AW-1:0] xoff, yoff;

  wire           wr_sel  = !wr_cs_n && wr_en;
  wire           loading = ld_cnt != 2'd2;
  wire [PW-1:0]  rb_s    = g2b(rg_s);
  wire [PW-1:0]  used    = wbin - rb_s;
  wire           wfull   = used == PW'(DEPTH);
  wire           wr_go   = wr_sel && !loading && !wfull;
  wire [PW-1:0]  wbin_nx = wbin + PW'(wr_go);
  wire [PW-1:0]  used_nx = wbin_nx - rb_s;
  wire [PW-1:0]  free_nx = PW'(DEPTH) - used_nx;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_m     <= '0;
      rg_s     <= '0;
      ld_cnt   <= (thr_sel == 2'b00) ? 2'd0 : 2'd2;
      xoff     <= preset(thr_sel);
      yoff     <= preset(thr_sel);
      wr_ready <= 1'b0;
      near_full_n <= 1'b1;
    end else begin
      rg_m     <= rgray;
      rg_s     <= rg_m;
      wbin     <= wbin_nx;
      wgray    <= wbin_nx ^ (wbin_nx >> 1);
      wr_ready <= used_nx != PW'(DEPTH);
      near_full_n <= !(free_nx <= {1'b0, yoff});
      if (wr_sel && loading) begin
        if (ld_cnt == 2'd0) xoff <= wdata[AW-1:0];
        else                yoff <= wdata[AW-1:0];
        ld_cnt <= ld_cnt + 2'd1;
      end
    end
  end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;

  // read domain
  logic [PW-1:0] rbin, rgray, wg_m, wg_s;
  logic          ov;

  wire           rd_sel  = !rd_cs_n && rd_en;
  wire [PW-1:0]  wb_s    = g2b(wg_s);
  wire           mem_ne  = wb_s != rbin;
  wire           pop     = rd_sel && (std_mode ? mem_ne : ov);
  wire           load    = std_mode ? pop : (mem_ne && (!ov || pop));
  wire [PW-1:0]  rbin_nx = rbin + PW'(load);
  wire           ov_nx   = !std_mode && (load || (ov && !pop));
  wire [CW-1:0]  cnt_nx  = {1'b0, wb_s - rbin_nx} + CW'(ov_nx);

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_m     <= '0;
      wg_s     <= '0;
      ov       <= 1'b0;
      rdata    <= '0;
      rd_ready <= 1'b0;
      near_empty_n <= 1'b0;
    end else begin
      wg_m     <= wgray;
      wg_s     <= wg_m;
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      ov       <= ov_nx;
      if (load) rdata <= mem[rbin[AW-1:0]];
      rd_ready <= std_mode ? (rbin_nx != wb_s) : ov_nx;
      near_empty_n <= !(cnt_nx <= CW'(xoff));
    end
  end

  assert_wptr_gated_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_sel |=> $stable(wbin));
  assert_rptr_gated_R1: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_sel && std_mode |=> $stable(rbin));
  assert_ready_means_data_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    std_mode && rd_ready |-> mem_ne);
  assert_fwft_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    !std_mode && ov && !rd_sel |=> ov && $stable(rdata));
  assert_load_not_stored_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    loading |=> $stable(wbin));
  assert_no_overflow_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    used <= PW'(DEPTH));
  assert_full_blocks_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    wfull |=> $stable(wbin));
endmodule

// File: tb/dcfifo_progflag_bench.sv
`timescale 1ns/100ps
module dcfifo_progflag_bench;
  logic        wclk = 0, rclk = 0, rst_n = 0, std_mode = 1;
  logic [1:0]  thr_sel = 2'b01;
  logic        wr_cs_n = 0, wr_en = 0, rd_cs_n = 0, rd_en = 0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rd_ready, wr_ready, near_empty_n, near_full_n;
  int n_run = 0, n_fail = 0;

  always #2.5 wclk = ~wclk;
  initial begin #1; forever #3.5 rclk = ~rclk; end

  dcfifo_progflag u_dcfifo_progflag (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .std_mode(std_mode), .thr_sel(thr_sel),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wdata(wdata), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
    .rdata(rdata), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .near_empty_n(near_empty_n), .near_full_n(near_full_n));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic [1:0] s);
    rst_n = 0; std_mode = m; thr_sel = s; wr_en = 0; rd_en = 0; wr_cs_n = 0; rd_cs_n = 0;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk) rst_n = 1;
  endtask

  task automatic settle;
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic wr_word(input logic [35:0] d);
    @(negedge wclk); wr_en = 1; wdata = d;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic rd_pulse;
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; std_mode = 1; thr_sel = 2'b01;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    check("R10 rd_ready in reset", rd_ready, 0);
    check("R10 wr_ready in reset", wr_ready, 0);
    check("R10 near_empty_n in reset", near_empty_n, 0);
    check("R10 near_full_n in reset", near_full_n, 1);
    rst_n = 1;
    settle;
    check("R10 wr_ready after release", wr_ready, 1);
  endtask

  task automatic t_gating;
    do_reset(1, 2'b01);
    @(negedge wclk); wr_cs_n = 1; wr_en = 1; wdata = 36'h0AA;
    @(negedge wclk); wr_cs_n = 0; wr_en = 0;
    @(negedge wclk); wr_en = 0;
    settle;
    check("R1 blocked writes stored nothing", rd_ready, 0);
    wr_word(36'h111);
    settle;
    check("R1 enabled write stored", rd_ready, 1);
    @(negedge rclk); rd_cs_n = 1; rd_en = 1;
    @(negedge rclk); rd_cs_n = 0; rd_en = 0;
    check("R1 deselected read left rdata", rdata, 0);
    check("R1 deselected read left word", rd_ready, 1);
    rd_pulse;
    check("R1 enabled read data", rdata, 36'h111);
    settle;
    check("R1 read emptied fifo", rd_ready, 0);
  endtask

  task automatic t_std_order;
    do_reset(1, 2'b01);
    for (int i = 0; i < 5; i++) wr_word(36'hA00 + 36'(i));
    settle;
    for (int i = 0; i < 5; i++) begin
      rd_pulse;
      check("R2 standard read order", rdata, 36'hA00 + 36'(i));
    end
    settle;
    check("R2 empty after draining", rd_ready, 0);
  endtask

  task automatic t_fill_presets;
    int errs;
    do_reset(1, 2'b01);
    for (int i = 0; i < 8; i++) wr_word(36'h1000 + 36'(i));
    settle;
    check("R5 R7 eight words at threshold 8", near_empty_n, 0);
    wr_word(36'h1008);
    settle;
    check("R5 R7 nine words above threshold 8", near_empty_n, 1);
    for (int i = 9; i < 247; i++) wr_word(36'h1000 + 36'(i));
    settle;
    check("R6 nine free above threshold 8", near_full_n, 1);
    wr_word(36'h1000 + 36'd247);
    settle;
    check("R6 R7 eight free at threshold 8", near_full_n, 0);
    for (int i = 248; i < 256; i++) wr_word(36'h1000 + 36'(i));
    settle;
    check("R4 full drops wr_ready", wr_ready, 0);
    wr_word(36'hDEAD);
    settle;
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      rd_pulse;
      if (rdata !== 36'h1000 + 36'(i)) errs++;
    end
    check("R2 R9 full drain order mismatches", 64'(errs), 0);
    settle;
    check("R9 write while full was dropped", rd_ready, 0);
    check("R4 space after drain", wr_ready, 1);
    rd_pulse;
    wr_word(36'h77);
    settle;
    rd_pulse;
    check("R9 read while empty ignored", rdata, 36'h77);
  endtask

  task automatic t_presets;
    do_reset(1, 2'b10);
    for (int i = 0; i < 16; i++) wr_word(36'(i));
    settle;
    check("R7 sel 10 sixteen words", near_empty_n, 0);
    wr_word(36'h99);
    settle;
    check("R7 sel 10 seventeen words", near_empty_n, 1);
    do_reset(1, 2'b11);
    for (int i = 0; i < 64; i++) wr_word(36'(i));
    settle;
    check("R7 sel 11 sixty-four words", near_empty_n, 0);
    wr_word(36'h99);
    settle;
    check("R7 sel 11 sixty-five words", near_empty_n, 1);
  endtask

  task automatic t_fwft;
    do_reset(0, 2'b01);
    wr_word(36'hB0);
    settle;
    check("R3 first word falls through valid", rd_ready, 1);
    check("R3 first word on output", rdata, 36'hB0);
    wr_word(36'hB1);
    wr_word(36'hB2);
    settle;
    check("R3 head held without read", rdata, 36'hB0);
    rd_pulse;
    check("R3 read advances to second", rdata, 36'hB1);
    rd_pulse;
    check("R3 read advances to third", rdata, 36'hB2);
    rd_pulse;
    check("R3 last read clears valid", rd_ready, 0);
    for (int i = 0; i < 8; i++) wr_word(36'hC0 + 36'(i));
    settle;
    check("R5 fall-through eight held", near_empty_n, 0);
    wr_word(36'hC8);
    settle;
    check("R5 fall-through nine held", near_empty_n, 1);
  endtask

  task automatic t_load;
    do_reset(1, 2'b00);
    wr_word(36'd3);
    wr_word(36'd5);
    for (int i = 0; i < 3; i++) wr_word(36'hD00 + 36'(i));
    settle;
    check("R8 loaded X=3 three words", near_empty_n, 0);
    wr_word(36'hD03);
    settle;
    check("R8 loaded X=3 four words", near_empty_n, 1);
    rd_pulse;
    check("R8 offset words not stored", rdata, 36'hD00);
    for (int i = 0; i < 247; i++) wr_word(36'hE00 + 36'(i));
    settle;
    check("R8 loaded Y=5 six free", near_full_n, 1);
    wr_word(36'hEFF);
    settle;
    check("R8 loaded Y=5 five free", near_full_n, 0);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_gating;
    t_std_order;
    t_fill_presets;
    t_presets;
    t_fwft;
    t_load;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule